// File: doc/BRIEF.md
# Three-Byte Sticky Interrupt Collector

This block gathers twenty-four single-bit event inputs into sticky status bits and drives one active-high, level-sensitive interrupt request toward a host processor. The status bits are packed into three byte-wide registers. Sources 0 to 7 are in the first byte, 8 to 15 in the second and 16 to 23 in the third. In each byte, bit 0 holds the lowest-numbered source. Each source has two mask bits. The status mask decides whether an event is recorded at all. The line mask decides whether a recorded event reaches the interrupt output.

The host reaches every register through a byte-wide register port. An access on which `acc_first` is high uses the address on `acc_addr`. Each further beat with `acc_first` low goes to the address after the previous beat. This lets one three-beat burst read all three status bytes, or write a whole mask set. A single write of any value to any status byte clears all twenty-four status bits. The host therefore reads the status with one burst and then acknowledges everything with one write.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, every status byte reads 0x00, every mask byte reads 0xFF and `irq_o` is low.
- R2: Status bytes are at addresses 0, 1 and 2. Source n maps to byte n/8, bit n%8. A source that is high at a clock edge while its status-mask bit is 0 sets that status bit at that edge.
- R3: A set status bit stays set after its source returns low, until the status bytes are cleared.
- R4: A source whose status-mask bit is 1 never sets its status bit.
- R5: A write beat of any data value to address 0, 1 or 2 clears all status bits at that edge.
- R6: If a source event and a status clear fall on the same edge, the event wins: its bit is set after that edge and all other bits are clear.
- R7: `irq_o` is registered. It equals the OR over all sources of (status AND NOT line mask), taken one edge after the status or mask change. A status bit whose line-mask bit is 1 stays readable but does not raise `irq_o`.
- R8: Line-mask bytes are at addresses 4, 5 and 6, and status-mask bytes are at addresses 8, 9 and 10, in source-byte order. Each mask byte reads back all eight bits exactly as last written. Bit value 1 means masked.
- R9: A beat with `acc_first` high uses `acc_addr`. Each later beat with `acc_first` low uses the previous beat's address plus one. Read data appears on `rd_data_o` with `rd_valid_o` high one edge after the beat.
- R10: Source 23 is reserved. Its status bit (address 2, bit 7) never sets and always reads 0.
- R11: Addresses 3, 7 and 11 to 15 are unmapped. Reads there return 0x00, and writes there change no register and clear no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 24 | Event inputs, one per source |
| acc_valid_i | input | 1 | Register access beat in this cycle |
| acc_first_i | input | 1 | Beat starts a burst at `acc_addr_i` |
| acc_write_i | input | 1 | Beat is a write (1) or a read (0) |
| acc_addr_i | input | 4 | Start address of a burst |
| acc_wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| rd_valid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Level interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- Status bits are sticky.
- Newly set bits were unmasked for recording at the preceding edge.
- A clear with no qualifying event leaves all bits zero.
- Each written mask byte holds the written value.
- The burst pointer advances by one per beat.
- `irq_o` tracks the masked status with one cycle of lag.
- The reserved bit never reaches the status.

Other behaviour can only be shown by the directed scenarios:
- The byte and bit placement of each source.
- The ordering within a burst.
- The event-wins rule on a coinciding clear.
- The silence of unmapped addresses.
- The exact cycle in which the request rises and falls.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] reg_byte_t;
endpackage

// File: rtl/evt_addr_ptr.sv
module evt_addr_ptr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid_i,
  input  logic              acc_first_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic [ADDR_W-1:0] cur_addr_o
);
  logic [ADDR_W-1:0] ptr_q;

  assign cur_addr_o = acc_first_i ? acc_addr_i : ptr_q;

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (acc_valid_i) ptr_q <= cur_addr_o + ADDR_W'(1);
  end

  // R9: every beat moves the pointer one past the address it used
  p_ptr_step_r9: assert property (@(posedge clk) disable iff (rst)
    acc_valid_i |=> ptr_q == $past(cur_addr_o) + ADDR_W'(1));
endmodule

// File: rtl/evt_group_decode.sv
module evt_group_decode #(
  parameter int ADDR_W    = 4,
  parameter int BASE      = 0,
  parameter int NUM_BYTES = 3,
  parameter int IDX_W     = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0] off;

  assign off   = addr_i - ADDR_W'(BASE);
  assign hit_o = off < ADDR_W'(NUM_BYTES);
  assign idx_o = off[IDX_W-1:0];
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank
  import evt_irq_pkg::*;
#(
  parameter int NUM_BYTES = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_BYTES-1:0]          wr_en_i,
  input  reg_byte_t                     wdata_i,
  output logic [NUM_BYTES*BYTE_W-1:0]   bits_o
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    reg_byte_t byte_q;

    always_ff @(posedge clk) begin
      if (rst) byte_q <= '1;
      else if (wr_en_i[g]) byte_q <= wdata_i;
    end

    assign bits_o[g*BYTE_W +: BYTE_W] = byte_q;

    // R8: a written mask byte holds exactly the written value
    p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
      wr_en_i[g] |=> byte_q == $past(wdata_i));
  end
endmodule

// File: rtl/evt_status_latch.sv
module evt_status_latch #(
  parameter int NUM_SRC  = 24,
  parameter int RSVD_SRC = 23
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] smask_i,
  input  logic [NUM_SRC-1:0] lmask_i,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic               irq_o
);
  localparam logic [NUM_SRC-1:0] KEEP = ~(NUM_SRC'(1) << RSVD_SRC);

  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] arrive;
  logic [NUM_SRC-1:0] held;
  logic               irq_q;

  assign arrive = src_i & ~smask_i & KEEP;
  assign held   = clr_i ? '0 : status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= held | arrive;
      irq_q    <= |(status_q & ~lmask_i);
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R3: without a clear no status bit ever drops
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (status_q & $past(status_q)) == $past(status_q));

  // R4: bits that newly set were unmasked for recording
  p_masked_no_set_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_q & ~$past(status_q) & $past(smask_i)) == '0);

  // R5: a clear with nothing arriving empties the status
  p_clear_all_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_i && ((src_i & ~smask_i) == '0)) |=> status_q == '0);

  // R7: request follows masked status one edge later
  p_irq_lag_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_q == |($past(status_q) & ~$past(lmask_i)));
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC   = 24,
  parameter int ADDR_W    = 4,
  parameter int STS_BASE  = 0,
  parameter int LMSK_BASE = 4,
  parameter int SMSK_BASE = 8,
  parameter int RSVD_SRC  = 23
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               acc_valid_i,
  input  logic               acc_first_i,
  input  logic               acc_write_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [BYTE_W-1:0]  acc_wdata_i,
  output logic [BYTE_W-1:0]  rd_data_o,
  output logic               rd_valid_o,
  output logic               irq_o
);
  localparam int NUM_BYTES = NUM_SRC / BYTE_W;
  localparam int IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  logic [ADDR_W-1:0]  cur_addr;
  logic               sts_hit, lmsk_hit, smsk_hit;
  logic [IDX_W-1:0]   sts_idx, lmsk_idx, smsk_idx;
  logic [NUM_BYTES-1:0] lmsk_we, smsk_we;
  logic [NUM_SRC-1:0] lmask, smask, status;
  logic               wr_beat, rd_beat, clr;
  reg_byte_t          rd_next, rd_q;
  logic               rd_valid_q;

  evt_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .acc_valid_i(acc_valid_i),
    .acc_first_i(acc_first_i), .acc_addr_i(acc_addr_i),
    .cur_addr_o(cur_addr));

  evt_group_decode #(.ADDR_W(ADDR_W), .BASE(STS_BASE),
    .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_dec_sts (
    .addr_i(cur_addr), .hit_o(sts_hit), .idx_o(sts_idx));

  evt_group_decode #(.ADDR_W(ADDR_W), .BASE(LMSK_BASE),
    .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_dec_lmsk (
    .addr_i(cur_addr), .hit_o(lmsk_hit), .idx_o(lmsk_idx));

  evt_group_decode #(.ADDR_W(ADDR_W), .BASE(SMSK_BASE),
    .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_dec_smsk (
    .addr_i(cur_addr), .hit_o(smsk_hit), .idx_o(smsk_idx));

  assign wr_beat = acc_valid_i && acc_write_i;
  assign rd_beat = acc_valid_i && !acc_write_i;
  assign clr     = wr_beat && sts_hit;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_we
    assign lmsk_we[g] = wr_beat && lmsk_hit && (int'(lmsk_idx) == g);
    assign smsk_we[g] = wr_beat && smsk_hit && (int'(smsk_idx) == g);
  end

  evt_mask_bank #(.NUM_BYTES(NUM_BYTES)) u_lmask (
    .clk(clk), .rst(rst), .wr_en_i(lmsk_we), .wdata_i(acc_wdata_i),
    .bits_o(lmask));

  evt_mask_bank #(.NUM_BYTES(NUM_BYTES)) u_smask (
    .clk(clk), .rst(rst), .wr_en_i(smsk_we), .wdata_i(acc_wdata_i),
    .bits_o(smask));

  evt_status_latch #(.NUM_SRC(NUM_SRC), .RSVD_SRC(RSVD_SRC)) u_status (
    .clk(clk), .rst(rst), .src_i(src_i), .smask_i(smask),
    .lmask_i(lmask), .clr_i(clr), .status_o(status), .irq_o(irq_o));

  always_comb begin
    rd_next = '0;
    if (sts_hit)       rd_next = status[int'(sts_idx)*BYTE_W +: BYTE_W];
    else if (lmsk_hit) rd_next = lmask[int'(lmsk_idx)*BYTE_W +: BYTE_W];
    else if (smsk_hit) rd_next = smask[int'(smsk_idx)*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q       <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_beat;
      if (rd_beat) rd_q <= rd_next;
    end
  end

  assign rd_data_o  = rd_q;
  assign rd_valid_o = rd_valid_q;

  // R1: request is low in the cycle after reset
  p_irq_low_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> !irq_o);

  // R10: the reserved source never reaches the status
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (rst)
    status[RSVD_SRC] == 1'b0);
endmodule

// File: tb/test_evt_irq_hub.sv
module test_evt_irq_hub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] src = '0;
  logic        acc_valid = 1'b0, acc_first = 1'b0, acc_write = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_valid, irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  evt_irq_hub i_evt_irq_hub (
    .clk(clk), .rst(rst), .src_i(src), .acc_valid_i(acc_valid),
    .acc_first_i(acc_first), .acc_write_i(acc_write), .acc_addr_i(acc_addr),
    .acc_wdata_i(acc_wdata), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    acc_valid = 1'b0; acc_first = 1'b0; acc_write = 1'b0;
  endtask

  task automatic bus_write(logic [3:0] a, logic [7:0] d);
    acc_valid = 1'b1; acc_first = 1'b1; acc_write = 1'b1;
    acc_addr = a; acc_wdata = d;
    tick(); idle();
  endtask

  task automatic bus_read(logic [3:0] a, output logic [7:0] d);
    acc_valid = 1'b1; acc_first = 1'b1; acc_write = 1'b0; acc_addr = a;
    tick(); d = rd_data; idle();
  endtask

  task automatic burst_read3(logic [3:0] a, output logic [23:0] v);
    acc_valid = 1'b1; acc_first = 1'b1; acc_write = 1'b0; acc_addr = a;
    tick(); v[7:0] = rd_data; acc_first = 1'b0; acc_addr = 4'hF;
    tick(); v[15:8] = rd_data;
    tick(); v[23:16] = rd_data; idle();
  endtask

  task automatic burst_write3(logic [3:0] a, logic [23:0] v);
    acc_valid = 1'b1; acc_first = 1'b1; acc_write = 1'b1;
    acc_addr = a; acc_wdata = v[7:0];
    tick(); acc_first = 1'b0; acc_addr = 4'hF; acc_wdata = v[15:8];
    tick(); acc_wdata = v[23:16];
    tick(); idle();
  endtask

  task automatic pulse(logic [23:0] v);
    src = v; tick(); src = '0;
  endtask

  task automatic t_reset();
    logic [23:0] v;
    chk("R1 irq", irq, 0);
    burst_read3(0, v); chk("R1 status", v, 0);
    burst_read3(4, v); chk("R1 line mask", v, 24'hFFFFFF);
    burst_read3(8, v); chk("R1 status mask", v, 24'hFFFFFF);
  endtask

  task automatic t_mask_rw();
    logic [23:0] v;
    logic [7:0]  d;
    burst_write3(4, 24'hA5_3C_81);
    burst_read3(4, v); chk("R8 R9 line mask burst", v, 24'hA5_3C_81);
    bus_write(9, 8'h6E);
    bus_read(9, d); chk("R8 status mask byte", d, 8'h6E);
    chk("R9 read valid", rd_valid, 1);
    burst_write3(4, 24'hFFFFFF);
    burst_write3(8, 24'h000000);
  endtask

  task automatic t_latch();
    logic [23:0] v;
    pulse(24'h400201);
    burst_read3(0, v); chk("R2 R9 status placement", v, 24'h40_02_01);
    chk("R7 line-masked no irq", irq, 0);
    tick(); tick();
    burst_read3(0, v); chk("R3 sticky", v, 24'h40_02_01);
  endtask

  task automatic t_irq();
    logic [23:0] v;
    bus_write(5, 8'hFD);
    chk("R7 irq not yet", irq, 0);
    tick(); chk("R7 irq rises", irq, 1);
    bus_write(1, 8'h5A);
    chk("R7 irq lags clear", irq, 1);
    tick(); chk("R5 irq falls", irq, 0);
    burst_read3(0, v); chk("R5 all cleared", v, 0);
    bus_write(5, 8'hFF);
  endtask

  task automatic t_race();
    logic [23:0] v;
    pulse(24'h000011);
    src = 24'h010000;
    acc_valid = 1'b1; acc_first = 1'b1; acc_write = 1'b1;
    acc_addr = 2; acc_wdata = 8'h00;
    tick(); idle(); src = '0;
    burst_read3(0, v); chk("R6 event wins", v, 24'h01_00_00);
    bus_write(0, 8'hFF);
  endtask

  task automatic t_smask();
    logic [23:0] v;
    bus_write(8, 8'hFE);
    pulse(24'h0000FF);
    burst_read3(0, v); chk("R4 masked sources ignored", v, 24'h000001);
    bus_write(0, 8'h00);
    bus_write(8, 8'h00);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    pulse(24'hFFFFFF);
    bus_read(2, d); chk("R10 reserved bit", d, 8'h7F);
    bus_write(2, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0]  d;
    logic [23:0] v;
    pulse(24'h000004);
    bus_write(3, 8'h77); bus_write(7, 8'h77); bus_write(11, 8'h77);
    bus_read(3, d);  chk("R11 read 3", d, 0);
    bus_read(7, d);  chk("R11 read 7", d, 0);
    bus_read(14, d); chk("R11 read 14", d, 0);
    burst_read3(0, v); chk("R11 status untouched", v, 24'h000004);
    burst_read3(4, v); chk("R11 line mask untouched", v, 24'hFFFFFF);
    burst_read3(8, v); chk("R11 status mask untouched", v, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_mask_rw();
    t_latch();
    t_irq();
    t_race();
    t_smask();
    t_reserved();
    t_unmapped();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule